// File: doc/BRIEF.md
# Integer Execution Unit with Compares

This block is the integer datapath of a processor pipeline stage. On each clock where `in_valid` is high, it reads a 6-bit operation code and two 32-bit operands. One clock edge later it presents the 32-bit result. The operations are bitwise logic, wrapping add and subtract, low and high multiply, three kinds of shift, leading and trailing zero counts, signed and unsigned compares, a move, and sign extension. Decode happens upstream. When an instruction carries an immediate, that immediate arrives already sign-extended on `op_b`, so register and immediate forms share one opcode.

The block has no state machine. Its only state is the output register stage: `result`, `illegal_op` and `result_valid`. That stage loads on every accepted operation and holds its data while the input is idle. Four combinational sub-units feed one result selector: logic/arithmetic/shift, multiply, bit count, and compare. An opcode with no defined meaning produces a zero result and sets `illegal_op`.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 1 gives `op_a | op_b`, opcode 2 gives `op_a & op_b`, and opcode 3 gives `op_a ^ op_b`.
- R2: Opcode 4 gives `op_a + op_b` and opcode 5 gives `op_a - op_b`, both wrapping modulo 2^32.
- R3: Opcode 6 gives bits [31:0] of the product. Opcode 7 gives bits [63:32] of the signed 64-bit product. Opcode 8 gives bits [63:32] of the unsigned 64-bit product.
- R4: Opcode 9 shifts `op_a` arithmetically right, opcode 10 logically right, and opcode 11 left. The shift amount is `op_b[4:0]`, and the upper bits of `op_b` are ignored.
- R5: Opcode 12 gives the number of leading zeros of `op_a` and opcode 13 the number of trailing zeros. Both give 32 when `op_a` is zero.
- R6: Signed compares treat both operands as two's complement: 14 equal, 15 not equal, 16 greater, 17 greater-or-equal, 18 less, 19 less-or-equal. The result is 32'd1 when the condition holds and 32'd0 when it does not.
- R7: Unsigned compares are 20 greater, 21 greater-or-equal, 22 less and 23 less-or-equal. They give 32'd1 or 32'd0 in the same way.
- R8: Opcode 32 passes `op_a` through unchanged. Opcode 43 sign-extends `op_a[7:0]` and opcode 44 sign-extends `op_a[15:0]`.
- R9: Every other opcode value gives a result of zero with `illegal_op` set to 1. Every defined opcode gives `illegal_op` of 0.
- R10: `result_valid` equals `in_valid` delayed by one clock. `result` and `illegal_op` update one clock after an accepted operation and hold their values while `in_valid` is low.
- R11: A synchronous active-high `rst` clears `result_valid`, `result` and `illegal_op` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 6 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand or pre-extended immediate |
| result | output | 32 | Registered result |
| result_valid | output | 1 | Result is from the operation accepted on the previous edge |
| illegal_op | output | 1 | Registered undefined-opcode flag |

## Verification
Every result, including the illegal flag, is due exactly one rising edge after the operation is presented, and `result_valid` follows `in_valid` with that same single-edge delay. The bench drives inputs on the falling edge. On the next falling edge it compares all three outputs against a behavioural model that keeps its expectation one operation deep. While the input is idle, the model expects the held values. The bench samples only after the edge that loads the register, so an output that comes too early or too late shows up as a mismatch.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPW = 6;

    typedef enum logic [OPW-1:0] {
        OP_OR    = 6'd1,
        OP_AND   = 6'd2,
        OP_XOR   = 6'd3,
        OP_ADD   = 6'd4,
        OP_SUB   = 6'd5,
        OP_MULLO = 6'd6,
        OP_MULHS = 6'd7,
        OP_MULHU = 6'd8,
        OP_SRA   = 6'd9,
        OP_SRL   = 6'd10,
        OP_SLL   = 6'd11,
        OP_CLZ   = 6'd12,
        OP_CTZ   = 6'd13,
        OP_EQ    = 6'd14,
        OP_NE    = 6'd15,
        OP_GTS   = 6'd16,
        OP_GES   = 6'd17,
        OP_LTS   = 6'd18,
        OP_LES   = 6'd19,
        OP_GTU   = 6'd20,
        OP_GEU   = 6'd21,
        OP_LTU   = 6'd22,
        OP_LEU   = 6'd23,
        OP_MOV   = 6'd32,
        OP_SX8   = 6'd43,
        OP_SX16  = 6'd44
    } alu_op_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] shamt;
    assign shamt = b[SW-1:0];

    always_comb begin
        res = '0;
        case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_SRA:  res = W'($signed(a) >>> shamt);
            OP_SRL:  res = a >> shamt;
            OP_SLL:  res = a << shamt;
            OP_MOV:  res = a;
            OP_SX8:  res = {{(W-8){a[7]}}, a[7:0]};
            OP_SX16: res = {{(W-16){a[15]}}, a[15:0]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_mul_unit.sv
module alu_mul_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod_s;
    logic        [PW-1:0] prod_u;

    assign prod_s = PW'($signed(a)) * PW'($signed(b));
    assign prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    always_comb begin
        case (op)
            OP_MULHS: res = prod_s[PW-1:W];
            OP_MULHU: res = prod_u[PW-1:W];
            default:  res = prod_u[W-1:0];
        endcase
    end
endmodule

// File: rtl/alu_bitcount_unit.sv
module alu_bitcount_unit #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  a,
    output logic [CW-1:0] lead,
    output logic [CW-1:0] trail
);
    always_comb begin
        lead = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) lead = CW'(W - 1 - i);
        end
    end

    always_comb begin
        trail = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (a[i]) trail = CW'(i);
        end
    end
endmodule

// File: rtl/alu_compare_unit.sv
module alu_compare_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           hit
);
    logic eq, lts, ltu;

    assign eq  = (a == b);
    assign lts = ($signed(a) < $signed(b));
    assign ltu = (a < b);

    always_comb begin
        case (op)
            OP_EQ:   hit = eq;
            OP_NE:   hit = !eq;
            OP_GTS:  hit = !lts && !eq;
            OP_GES:  hit = !lts;
            OP_LTS:  hit = lts;
            OP_LES:  hit = lts || eq;
            OP_GTU:  hit = !ltu && !eq;
            OP_GEU:  hit = !ltu;
            OP_LTU:  hit = ltu;
            OP_LEU:  hit = ltu || eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [OPW-1:0] opcode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [W-1:0]   result,
    output logic           result_valid,
    output logic           illegal_op
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]  lg_res;
    logic [W-1:0]  mul_res;
    logic [CW-1:0] lead_cnt;
    logic [CW-1:0] trail_cnt;
    logic          cmp_hit;
    logic [W-1:0]  next_res;
    logic          next_ill;

    alu_logic_unit #(.W(W)) u_logic (
        .op(opcode), .a(op_a), .b(op_b), .res(lg_res)
    );

    alu_mul_unit #(.W(W)) u_mul (
        .op(opcode), .a(op_a), .b(op_b), .res(mul_res)
    );

    alu_bitcount_unit #(.W(W), .CW(CW)) u_count (
        .a(op_a), .lead(lead_cnt), .trail(trail_cnt)
    );

    alu_compare_unit #(.W(W)) u_cmp (
        .op(opcode), .a(op_a), .b(op_b), .hit(cmp_hit)
    );

    always_comb begin
        next_res = '0;
        next_ill = 1'b0;
        case (opcode)
            OP_OR, OP_AND, OP_XOR, OP_ADD, OP_SUB,
            OP_SRA, OP_SRL, OP_SLL, OP_MOV, OP_SX8, OP_SX16:
                next_res = lg_res;
            OP_MULLO, OP_MULHS, OP_MULHU:
                next_res = mul_res;
            OP_CLZ:
                next_res = W'(lead_cnt);
            OP_CTZ:
                next_res = W'(trail_cnt);
            OP_EQ, OP_NE, OP_GTS, OP_GES, OP_LTS, OP_LES,
            OP_GTU, OP_GEU, OP_LTU, OP_LEU:
                next_res = W'(cmp_hit);
            default:
                next_ill = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            result       <= '0;
            illegal_op   <= 1'b0;
        end else begin
            result_valid <= in_valid;
            if (in_valid) begin
                result     <= next_res;
                illegal_op <= next_ill;
            end
        end
    end

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> result_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!result_valid && $stable(result) && $stable(illegal_op)));

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (result == '0));

    // Covers the signed compares (R6) and the unsigned ones (R7).
    p_cmp_bool_r6: assert property (@(posedge clk) disable iff (rst)
        (result_valid && ($past(opcode) >= 6'd14) && ($past(opcode) <= 6'd23))
            |-> (result[W-1:1] == '0));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (result_valid && (($past(opcode) == 6'd12) || ($past(opcode) == 6'd13)))
            |-> (result <= W));

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!result_valid && !illegal_op && (result == '0)));
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic        result_valid;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_res = '0;
    logic        exp_ill = 1'b0;
    logic        exp_val = 1'b0;
    string       exp_tag = "R11";

    always #4 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .result(result),
        .result_valid(result_valid), .illegal_op(illegal_op)
    );

    function automatic string tag_of(input logic [5:0] op);
        if (op >= 1 && op <= 3) return "R1";
        if (op == 4 || op == 5) return "R2";
        if (op >= 6 && op <= 8) return "R3";
        if (op >= 9 && op <= 11) return "R4";
        if (op == 12 || op == 13) return "R5";
        if (op >= 14 && op <= 19) return "R6";
        if (op >= 20 && op <= 23) return "R7";
        if (op == 32 || op == 43 || op == 44) return "R8";
        return "R9";
    endfunction

    function automatic logic [32:0] model(input logic [5:0] op,
                                          input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, ps;
        logic [63:0] pu;
        int n;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ps = sa * sb;
        pu = {32'd0, a} * {32'd0, b};
        case (op)
            1:  return {1'b0, a | b};
            2:  return {1'b0, a & b};
            3:  return {1'b0, a ^ b};
            4:  return {1'b0, a + b};
            5:  return {1'b0, a - b};
            6:  return {1'b0, pu[31:0]};
            7:  return {1'b0, ps[63:32]};
            8:  return {1'b0, pu[63:32]};
            9:  return {1'b0, 32'(sa >>> b[4:0])};
            10: return {1'b0, a >> b[4:0]};
            11: return {1'b0, a << b[4:0]};
            12: begin
                n = 0;
                while (n < 32 && !a[31-n]) n++;
                return {1'b0, 32'(n)};
            end
            13: begin
                n = 0;
                while (n < 32 && !a[n]) n++;
                return {1'b0, 32'(n)};
            end
            14: return {1'b0, 32'(sa == sb)};
            15: return {1'b0, 32'(sa != sb)};
            16: return {1'b0, 32'(sa > sb)};
            17: return {1'b0, 32'(sa >= sb)};
            18: return {1'b0, 32'(sa < sb)};
            19: return {1'b0, 32'(sa <= sb)};
            20: return {1'b0, 32'(a > b)};
            21: return {1'b0, 32'(a >= b)};
            22: return {1'b0, 32'(a < b)};
            23: return {1'b0, 32'(a <= b)};
            32: return {1'b0, a};
            43: return {1'b0, {24{a[7]}}, a[7:0]};
            44: return {1'b0, {16{a[15]}}, a[15:0]};
            default: return {1'b1, 32'd0};
        endcase
    endfunction

    task automatic compare_outputs();
        checks++;
        if (result_valid !== exp_val || illegal_op !== exp_ill || result !== exp_res) begin
            errors++;
            $display("FAIL %s: got valid=%0b ill=%0b res=%08h, expected valid=%0b ill=%0b res=%08h",
                     exp_tag, result_valid, illegal_op, result, exp_val, exp_ill, exp_res);
        end
    endtask

    // Drive one cycle; the outputs from the previous cycle are checked first.
    task automatic step(input logic r, input logic v, input logic [5:0] op,
                        input logic [31:0] a, input logic [31:0] b);
        logic [32:0] m;
        @(negedge clk);
        compare_outputs();
        rst = r; in_valid = v; opcode = op; op_a = a; op_b = b;
        if (r) begin
            exp_val = 1'b0; exp_res = '0; exp_ill = 1'b0; exp_tag = "R11";
        end else begin
            exp_val = v;
            exp_tag = v ? tag_of(op) : "R10";
            if (v) begin
                m = model(op, a, b);
                exp_ill = m[32];
                exp_res = m[31:0];
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got running, expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [8];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h7FFF_FFFF;
        pats[4] = 32'h0000_0001; pats[5] = 32'h0000_0080;
        pats[6] = 32'h0000_8000; pats[7] = 32'hDEAD_BEEF;

        // R11: reset state
        step(1'b1, 1'b0, 6'd0, '0, '0);
        step(1'b1, 1'b0, 6'd0, '0, '0);
        step(1'b0, 1'b0, 6'd0, '0, '0);

        // Every opcode value against a grid of corner operands (R1..R9).
        for (int op = 0; op < 64; op++) begin
            for (int i = 0; i < 8; i++) begin
                step(1'b0, 1'b1, 6'(op), pats[i], pats[(i * 3 + 1) % 8]);
            end
            step(1'b0, 1'b1, 6'(op), pats[op % 8], pats[op % 8]);
        end

        // R4: shift amounts with upper bits set must use only the low 5 bits.
        step(1'b0, 1'b1, 6'd11, 32'h0000_0003, 32'h0000_0021);
        step(1'b0, 1'b1, 6'd10, 32'h8000_0000, 32'hFFFF_FFE4);
        step(1'b0, 1'b1, 6'd9,  32'h8000_0000, 32'h0000_003F);

        // R5: zero operand gives 32.
        step(1'b0, 1'b1, 6'd12, 32'h0, 32'h0);
        step(1'b0, 1'b1, 6'd13, 32'h0, 32'h0);

        // R10: idle cycles hold the previous result and illegal flag.
        step(1'b0, 1'b1, 6'd63, 32'h1234_5678, 32'h1);
        step(1'b0, 1'b0, 6'd4, 32'h1, 32'h1);
        step(1'b0, 1'b0, 6'd4, 32'h2, 32'h2);
        step(1'b0, 1'b1, 6'd4, 32'h1, 32'h2);
        step(1'b0, 1'b0, 6'd1, 32'hFFFF, 32'h0);

        // Random traffic with gaps.
        for (int k = 0; k < 3000; k++) begin
            logic [5:0] rop;
            rop = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 24);
            step(1'b0, ($urandom % 5) != 0, rop, $urandom, $urandom);
        end

        // R11: reset in the middle of traffic.
        step(1'b0, 1'b1, 6'd3, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
        step(1'b1, 1'b1, 6'd4, 32'h5, 32'h6);
        step(1'b0, 1'b0, 6'd0, '0, '0);
        step(1'b0, 1'b1, 6'd44, 32'h0000_9001, 32'h0);
        step(1'b0, 1'b0, 6'd0, '0, '0);
        step(1'b0, 1'b0, 6'd0, '0, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule